// File: doc/BRIEF.md
# Banked data address translator

This unit turns a data-memory reference of a small 8-bit core into a physical RAM address. A direct reference carries a 7-bit in-bank offset, and the bank register supplies the upper bits. An indirect reference carries a 16-bit pointer. Below the physical limit, the pointer names a banked location outright. From 0x2000 upward, it enters a linear window. That window presents every general-purpose byte of every bank as one unbroken run, with no special-function registers in it and no shared cells.

Each bank is split into three parts. Offsets 0x00 to 0x1F are special-function registers. Offsets 0x20 to 0x6F are 80 bytes of general RAM private to that bank. Offsets 0x70 to 0x7F are shared: these sixteen cells are the same whatever bank is selected, and they always resolve into bank 0. A 3-bit bank register sits inside the unit and has a write strobe. The address outputs are combinational from the current register value and the request inputs.

Top module: `bx_translator`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the bank register to 0, so after reset a direct offset 0x25 yields physical address 0x025.
- R2: When bank_we is high at a rising edge, the bank register takes bank_wdata. When bank_we is low, the register keeps its value.
- R3: A direct access (use_ind=0) with an offset in 0x00 to 0x6F yields phys_addr = bank*128 + offset. For example, bank 2 with offset 0x01 gives 0x101.
- R4: A direct offset in 0x70 to 0x7F yields phys_addr equal to the offset (bank 0) for every bank value, so that 0x70 under bank 3 and 0x70 under bank 0 are one cell.
- R5: is_sfr is 1 exactly when a valid banked access (direct, or indirect below 0x400) targets an in-bank offset below 0x20. It is 0 for all other offsets, for linear accesses and for invalid accesses.
- R6: An indirect access (use_ind=1) with a pointer below 0x400 uses pointer bits [9:7] as the bank and bits [6:0] as the offset, with the same shared folding as R4.
- R7: An indirect pointer p in 0x2000 to 0x227F maps with i = p-0x2000 to phys_addr = (i/80)*128 + (i%80) + 0x20. For example, 0x2000 gives 0x020, 0x204F gives 0x06F, 0x2050 gives 0x0A0 and 0x227F gives 0x3EF.
- R8: An indirect pointer in 0x0400 to 0x1FFF, or at or above 0x2280, sets bad_addr to 1 and drives phys_addr to 0. A direct access never sets bad_addr.
- R9: A direct access ignores ind_ptr entirely. The linear window cannot be reached through dir_ofs.
- R10: An indirect access ignores the bank register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 3 | Value loaded into the bank register |
| dir_ofs | input | 7 | Direct operand, the in-bank offset |
| ind_ptr | input | 16 | Indirect pointer |
| use_ind | input | 1 | 1 selects the indirect pointer, 0 the direct operand |
| phys_addr | output | 10 | Physical RAM address |
| is_sfr | output | 1 | Access targets a special-function register |
| bad_addr | output | 1 | Indirect pointer names no RAM cell |

## Verification
The hardest behaviour to reach is at the seams of the linear window. These seams are where one bank's 80 general bytes end and the next bank begins, the last valid byte 0x227F, and the first invalid pointer 0x2280. An off-by-one in the bank split only shows at these exact pointers. The stimulus therefore walks the pointer across 0x204F/0x2050 and 0x227F/0x2280, and across 0x03FF/0x0400 at the top of the banked range. Before each indirect step, the bank register is deliberately loaded with a nonzero value, so that any leak of the bank bits into the indirect path shows up.

// File: rtl/bx_pkg.sv
// Shared types for the banked address translator.
// Assumes: only the route encoding is shared; widths stay parameters of each module.
package bx_pkg;
    typedef enum logic [1:0] {
        ROUTE_DIRECT = 2'd0,
        ROUTE_BANKED = 2'd1,
        ROUTE_LINEAR = 2'd2,
        ROUTE_NONE   = 2'd3
    } route_t;
endpackage

// File: rtl/bx_bank_reg.sv
// Bank-select register: loads on a write strobe and clears on a synchronous
// active-low reset. Assumes a single clock domain.
module bx_bank_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);
    // Hold, load or clear the bank value.
    always_ff @(posedge clk) begin
        if (!rst_n)  bank <= '0;
        else if (we) bank <= wdata;
    end
endmodule

// File: rtl/bx_bank_map.sv
// Banked mapping: joins a bank number and an in-bank offset into a physical
// address. Offsets at or above SHARED_BASE are folded into bank 0, and offsets
// below SFR_TOP are flagged as special-function registers.
// Assumes SFR_TOP < SHARED_BASE <= 2**OFS_W.
module bx_bank_map #(
    parameter int BANK_W      = 3,
    parameter int OFS_W       = 7,
    parameter int SFR_TOP     = 32,
    parameter int SHARED_BASE = 112
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [OFS_W-1:0]        ofs,
    output logic [BANK_W+OFS_W-1:0] phys,
    output logic                    sfr
);
    localparam logic [OFS_W-1:0] SHARED_P = OFS_W'(SHARED_BASE);
    localparam logic [OFS_W-1:0] SFR_P    = OFS_W'(SFR_TOP);

    logic shared;

    // Pick bank 0 for the shared window, the given bank otherwise.
    always_comb begin
        shared = (ofs >= SHARED_P);
        phys   = shared ? {{BANK_W{1'b0}}, ofs} : {bank, ofs};
        sfr    = (ofs < SFR_P);
    end
endmodule

// File: rtl/bx_linear_map.sv
// Linear window decode: a pointer at LIN_BASE or above walks the general RAM
// of bank 0, then bank 1, and so on. Each bank contributes
// SHARED_BASE-SFR_TOP bytes starting at in-bank offset SFR_TOP.
// Assumes the window size fits in PTR_W bits.
module bx_linear_map #(
    parameter int BANK_W      = 3,
    parameter int OFS_W       = 7,
    parameter int PTR_W       = 16,
    parameter int SFR_TOP     = 32,
    parameter int SHARED_BASE = 112,
    parameter int LIN_BASE    = 'h2000
) (
    input  logic [PTR_W-1:0]        ptr,
    output logic                    hit,
    output logic [BANK_W+OFS_W-1:0] phys
);
    localparam int NB       = 1 << BANK_W;
    localparam int GP       = SHARED_BASE - SFR_TOP;
    localparam int LIN_SIZE = NB * GP;
    localparam logic [PTR_W-1:0] BASE_P = PTR_W'(LIN_BASE);
    localparam logic [PTR_W-1:0] SIZE_P = PTR_W'(LIN_SIZE);

    logic [PTR_W-1:0]  rel;
    logic [NB-1:0]     crossed;
    logic [BANK_W-1:0] bank_sel;
    logic [PTR_W-1:0]  in_bank_full;
    logic [PTR_W-1:0]  unused_hi;

    assign rel = ptr - BASE_P;
    assign hit = (ptr >= BASE_P) && (rel < SIZE_P);

    // One threshold comparator per bank boundary.
    for (genvar k = 0; k < NB; k++) begin : g_edge
        if (k == 0) begin : g_first
            assign crossed[k] = 1'b0;
        end else begin : g_rest
            assign crossed[k] = (rel >= PTR_W'(k * GP));
        end
    end

    // Count crossed boundaries to get the bank, then rebuild the offset.
    always_comb begin
        logic [BANK_W:0] cnt;
        cnt = '0;
        for (int k = 0; k < NB; k++) cnt = cnt + {{BANK_W{1'b0}}, crossed[k]};
        bank_sel     = cnt[BANK_W-1:0];
        in_bank_full = rel - PTR_W'(bank_sel) * PTR_W'(GP) + PTR_W'(SFR_TOP);
        unused_hi    = in_bank_full;
        phys         = hit ? {bank_sel, in_bank_full[OFS_W-1:0]} : '0;
    end
endmodule

// File: rtl/bx_translator.sv
// Banked data address translator, top level. A direct request uses the bank
// register and a 7-bit offset. An indirect request uses a pointer that is
// either a plain banked address, a linear-window address, or invalid.
// Assumes outputs are consumed combinationally in the same cycle.
module bx_translator
    import bx_pkg::*;
#(
    parameter int BANK_W      = 3,
    parameter int OFS_W       = 7,
    parameter int PTR_W       = 16,
    parameter int SFR_TOP     = 32,
    parameter int SHARED_BASE = 112,
    parameter int LIN_BASE    = 'h2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bank_we,
    input  logic [BANK_W-1:0]       bank_wdata,
    input  logic [OFS_W-1:0]        dir_ofs,
    input  logic [PTR_W-1:0]        ind_ptr,
    input  logic                    use_ind,
    output logic [BANK_W+OFS_W-1:0] phys_addr,
    output logic                    is_sfr,
    output logic                    bad_addr
);
    localparam int PHYS_W = BANK_W + OFS_W;

    logic [BANK_W-1:0] bank_q;
    logic [PHYS_W-1:0] d_phys, i_phys, l_phys;
    logic              d_sfr, i_sfr, l_hit;
    logic              ind_low;
    route_t            route;

    bx_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank(bank_q)
    );

    bx_bank_map #(.BANK_W(BANK_W), .OFS_W(OFS_W), .SFR_TOP(SFR_TOP),
                  .SHARED_BASE(SHARED_BASE)) u_dmap (
        .bank(bank_q), .ofs(dir_ofs), .phys(d_phys), .sfr(d_sfr)
    );

    bx_bank_map #(.BANK_W(BANK_W), .OFS_W(OFS_W), .SFR_TOP(SFR_TOP),
                  .SHARED_BASE(SHARED_BASE)) u_imap (
        .bank(ind_ptr[PHYS_W-1:OFS_W]), .ofs(ind_ptr[OFS_W-1:0]),
        .phys(i_phys), .sfr(i_sfr)
    );

    bx_linear_map #(.BANK_W(BANK_W), .OFS_W(OFS_W), .PTR_W(PTR_W),
                    .SFR_TOP(SFR_TOP), .SHARED_BASE(SHARED_BASE),
                    .LIN_BASE(LIN_BASE)) u_lmap (
        .ptr(ind_ptr), .hit(l_hit), .phys(l_phys)
    );

    assign ind_low = (ind_ptr >> PHYS_W) == '0;

    // Choose which mapping serves this request.
    always_comb begin
        if (!use_ind)     route = ROUTE_DIRECT;
        else if (ind_low) route = ROUTE_BANKED;
        else if (l_hit)   route = ROUTE_LINEAR;
        else              route = ROUTE_NONE;
    end

    // Drive the outputs from the chosen mapping.
    always_comb begin
        phys_addr = '0;
        is_sfr    = 1'b0;
        bad_addr  = 1'b0;
        unique case (route)
            ROUTE_DIRECT: begin phys_addr = d_phys; is_sfr = d_sfr; end
            ROUTE_BANKED: begin phys_addr = i_phys; is_sfr = i_sfr; end
            ROUTE_LINEAR: phys_addr = l_phys;
            ROUTE_NONE:   bad_addr = 1'b1;
        endcase
    end
endmodule

// File: rtl/bx_translator_chk.sv
// Property checker for bx_translator, attached by bind below.
// Assumes default-like geometry (shared window at the top of each bank).
module bx_translator_chk #(
    parameter int BANK_W      = 3,
    parameter int OFS_W       = 7,
    parameter int PTR_W       = 16,
    parameter int SFR_TOP     = 32,
    parameter int SHARED_BASE = 112,
    parameter int LIN_BASE    = 'h2000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bank_we,
    input logic [BANK_W-1:0]       bank_wdata,
    input logic [OFS_W-1:0]        dir_ofs,
    input logic [PTR_W-1:0]        ind_ptr,
    input logic                    use_ind,
    input logic [BANK_W+OFS_W-1:0] phys_addr,
    input logic                    is_sfr,
    input logic                    bad_addr,
    input logic [BANK_W-1:0]       bank_q
);
    localparam int LIN_END = LIN_BASE + (1 << BANK_W) * (SHARED_BASE - SFR_TOP);
    localparam logic [OFS_W-1:0] SHARED_P = OFS_W'(SHARED_BASE);
    localparam logic [OFS_W-1:0] SFR_P    = OFS_W'(SFR_TOP);

    logic in_win;
    assign in_win = use_ind && (ind_ptr >= PTR_W'(LIN_BASE)) && (ind_ptr < PTR_W'(LIN_END));

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> bank_q == $past(bank_wdata));
    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_q));
    assert_direct_concat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_ind && dir_ofs < SHARED_P) |-> phys_addr == {bank_q, dir_ofs});
    assert_shared_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_ind && dir_ofs >= SHARED_P) |-> phys_addr == {{BANK_W{1'b0}}, dir_ofs});
    assert_linear_gp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (!is_sfr && !bad_addr && phys_addr[OFS_W-1:0] >= SFR_P
                    && phys_addr[OFS_W-1:0] < SHARED_P));
    assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> (phys_addr == '0 && !is_sfr && use_ind));
    assert_direct_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !use_ind |-> !bad_addr);
endmodule

bind bx_translator bx_translator_chk #(
    .BANK_W(BANK_W), .OFS_W(OFS_W), .PTR_W(PTR_W), .SFR_TOP(SFR_TOP),
    .SHARED_BASE(SHARED_BASE), .LIN_BASE(LIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .dir_ofs(dir_ofs), .ind_ptr(ind_ptr), .use_ind(use_ind),
    .phys_addr(phys_addr), .is_sfr(is_sfr), .bad_addr(bad_addr), .bank_q(bank_q)
);

// File: tb/bx_translator_test.sv
// Directed bench for bx_translator: one task per scenario.
module bx_translator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [2:0]  bank_wdata = '0;
    logic [6:0]  dir_ofs = '0;
    logic [15:0] ind_ptr = '0;
    logic        use_ind = 1'b0;
    logic [9:0]  phys_addr;
    logic        is_sfr;
    logic        bad_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bx_translator uut (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .dir_ofs(dir_ofs), .ind_ptr(ind_ptr), .use_ind(use_ind),
        .phys_addr(phys_addr), .is_sfr(is_sfr), .bad_addr(bad_addr)
    );

    always #2 clk = ~clk;

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic int exp_banked(int bank, int ofs);
        return (ofs >= 'h70) ? ofs : bank * 128 + ofs;
    endfunction

    function automatic int exp_linear(int p);
        int i = p - 'h2000;
        return (i / 80) * 128 + (i % 80) + 'h20;
    endfunction

    task automatic set_bank(logic [2:0] b);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = b;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    task automatic direct(logic [6:0] o);
        @(negedge clk);
        use_ind = 1'b0; dir_ofs = o;
        #1;
    endtask

    task automatic indirect(logic [15:0] p);
        @(negedge clk);
        use_ind = 1'b1; ind_ptr = p;
        #1;
    endtask

    task automatic t_reset;
        set_bank(3'd5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        direct(7'h25);
        check("R1 reset bank", int'(phys_addr), 'h025);
        check("R1 reset flag", int'(bad_addr), 0);
    endtask

    task automatic t_bank_write;
        set_bank(3'd6);
        direct(7'h30);
        check("R2 load", int'(phys_addr), exp_banked(6, 'h30));
        @(negedge clk); bank_we = 1'b0; bank_wdata = 3'd1;
        @(negedge clk); #1;
        check("R2 hold", int'(phys_addr), exp_banked(6, 'h30));
    endtask

    task automatic t_direct;
        set_bank(3'd2);
        direct(7'h01);
        check("R3 bank2 0x01", int'(phys_addr), 'h101);
        set_bank(3'd7);
        direct(7'h6F);
        check("R3 bank7 0x6F", int'(phys_addr), exp_banked(7, 'h6F));
        direct(7'h00);
        check("R3 bank7 0x00", int'(phys_addr), 'h380);
    endtask

    task automatic t_shared;
        for (int b = 0; b < 8; b += 3) begin
            set_bank(3'(b));
            direct(7'h70);
            check("R4 shared 0x70", int'(phys_addr), 'h070);
            direct(7'h7F);
            check("R4 shared 0x7F", int'(phys_addr), 'h07F);
        end
    endtask

    task automatic t_sfr;
        set_bank(3'd4);
        direct(7'h1F);
        check("R5 sfr top", int'(is_sfr), 1);
        direct(7'h20);
        check("R5 gp low", int'(is_sfr), 0);
        direct(7'h75);
        check("R5 shared", int'(is_sfr), 0);
        indirect(16'h0085);
        check("R5 ind sfr", int'(is_sfr), 1);
        indirect(16'h2000);
        check("R5 linear", int'(is_sfr), 0);
    endtask

    task automatic t_ind_banked;
        set_bank(3'd5);
        indirect(16'h0101);
        check("R6 ind 0x101", int'(phys_addr), 'h101);
        check("R10 bank ignored", int'(phys_addr), exp_banked(2, 'h01));
        indirect(16'h01F0);
        check("R6 ind shared fold", int'(phys_addr), 'h070);
        indirect(16'h03FF);
        check("R6 ind top", int'(phys_addr), 'h07F);
        check("R6 ind top ok", int'(bad_addr), 0);
    endtask

    task automatic t_linear;
        set_bank(3'd3);
        indirect(16'h2000);
        check("R7 lin base", int'(phys_addr), 'h020);
        indirect(16'h204F);
        check("R7 lin end bank0", int'(phys_addr), 'h06F);
        indirect(16'h2050);
        check("R7 lin bank1", int'(phys_addr), 'h0A0);
        indirect(16'h2123);
        check("R7 lin mid", int'(phys_addr), exp_linear('h2123));
        indirect(16'h227F);
        check("R7 lin last", int'(phys_addr), 'h3EF);
        check("R10 lin valid", int'(bad_addr), 0);
    endtask

    task automatic t_invalid;
        set_bank(3'd1);
        indirect(16'h0400);
        check("R8 gap low", int'(bad_addr), 1);
        check("R8 gap addr", int'(phys_addr), 0);
        indirect(16'h1FFF);
        check("R8 gap high", int'(bad_addr), 1);
        indirect(16'h2280);
        check("R8 past window", int'(bad_addr), 1);
        check("R8 past addr", int'(phys_addr), 0);
        indirect(16'hFFFF);
        check("R8 top", int'(bad_addr), 1);
        check("R8 top sfr", int'(is_sfr), 0);
    endtask

    task automatic t_direct_ignores_ptr;
        set_bank(3'd2);
        @(negedge clk);
        ind_ptr = 16'h2000; use_ind = 1'b0; dir_ofs = 7'h20;
        #1;
        check("R9 direct addr", int'(phys_addr), 'h120);
        check("R9 direct valid", int'(bad_addr), 0);
        @(negedge clk); ind_ptr = 16'h0400; #1;
        check("R9 ptr change", int'(phys_addr), 'h120);
        check("R9 still valid", int'(bad_addr), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank_write();
        t_direct();
        t_shared();
        t_sfr();
        t_ind_banked();
        t_linear();
        t_invalid();
        t_direct_ignores_ptr();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule